// File: doc/BRIEF.md
# Single-Wire Request/Grant Bus Arbiter

This block is the processor side of a bus handover scheme. Each external bus master has its own active-low wire, pulled high when nobody drives it. Three one-clock low pulses run over that one wire, each in turn:

- the master asks for the bus;
- the processor answers with a grant;
- later, the master hands the bus back.

Between the grant and the hand-back, the processor floats its local bus.

The grant is timed against the processor's own bus cycle. It may only fall in the last clock of a cycle, or in a clock with no cycle running. It is held back in these cases:

- the request came too late in the current cycle;
- the cycle is the first half of a split word access;
- the cycle is the first of an interrupt-acknowledge pair;
- a locked instruction is running.

A blocked request stays pending and is granted at the next clock where a grant is allowed. The lowest-numbered channel wins when several requests are pending. After each hand-back, one dead clock passes before the processor drives the bus again.

The wire is split into a sampled level (`line_in`) and a pull-down enable (`line_drive_low`). The surrounding pad logic forms the open-drain wire from these two.

Top module: `rg_bus_arbiter`

## Requirements
- R1: After a synchronous reset, `line_drive_low` is all zero, `bus_float` is 0, and no request is pending.
- R2: While the processor owns the bus, a low sample on a channel's wire records a request on that channel. The only exception is the clock in which the processor is driving that wire itself. A grant is exactly one clock of `line_drive_low` high on the granted channel, and the processor drives no wire in any other clock.
- R3: A grant occurs only when `bus_phase` is T4 (5) or IDLE (0). The other codes are T1=1, T2=2, T3=3 and TW=4. A request seen in an IDLE clock is granted in the next clock if that clock is also IDLE. `bus_float` rises in the clock after the grant.
- R4: A request sampled in a T3, TW or T4 clock is not granted in the T4 of that same bus cycle. It is granted at the T4 of a later cycle, or at an IDLE clock.
- R5: No grant is given in a T4 clock while `split_low_half` or `inta_first` is 1. The request stays pending.
- R6: No grant is given in any clock while `locked` is 1. The request stays pending.
- R7: When several eligible requests are pending in the same grant clock, the lowest-numbered channel is granted.
- R8: `bus_float` stays 1 until a low pulse on the granted channel's wire. A low pulse on another channel during that time does not end the float, and it is recorded as a request.
- R9: After the release pulse is sampled, `bus_float` stays 1 for one dead clock and then falls to 0. No grant is given in the dead clock. A pending request on another channel can be granted from the clock after that, at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NCH | Sampled level of each request/grant wire (1 = released/pulled up) |
| bus_phase | input | 3 | Current bus-cycle state: 0 IDLE, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4 |
| locked | input | 1 | A locked instruction is executing |
| inta_first | input | 1 | Current cycle is the first of an interrupt-acknowledge pair |
| split_low_half | input | 1 | Current cycle is the first half of a split word access at an odd address |
| line_drive_low | output | NCH | Pull-down enable per wire, high only in the grant clock |
| bus_float | output | 1 | Local bus drivers are released (high impedance) |

## Verification
The in-RTL assertions check these properties on every clock:

- at most one wire is driven, and only in a T4 or IDLE clock;
- no wire is driven while locked, or during the float and dead clocks;
- the lowest eligible channel wins;
- the float follows every grant;
- the dead clock always returns to ownership.

Some behaviours only the bench scenarios can show. These are the late-request deferral across a whole bus cycle, the pending request that survives split, interrupt-acknowledge and lock blocking, and the request recorded on the other channel during a float. The bench then checks that this request is serviced only after the dead clock.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_t;

    typedef enum logic [1:0] {
        ST_OWN  = 2'd0,
        ST_HELD = 2'd1,
        ST_DEAD = 2'd2
    } own_state_t;

    // A request seen in these clocks is too late for this cycle's T4.
    function automatic logic is_late_phase(input phase_t ph);
        return (ph == PH_T3) || (ph == PH_TW) || (ph == PH_T4);
    endfunction

    // Clock in which a grant pulse may be issued at all.
    function automatic logic grant_window(input phase_t ph,
                                          input logic   lock_i,
                                          input logic   split_i,
                                          input logic   inta_i);
        logic ok;
        ok = 1'b0;
        if (!lock_i) begin
            if (ph == PH_IDLE)
                ok = 1'b1;
            else if (ph == PH_T4 && !split_i && !inta_i)
                ok = 1'b1;
        end
        return ok;
    endfunction

endpackage

// File: rtl/rg_line_monitor.sv
module rg_line_monitor
    import rg_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] line_in,
    input  logic [NCH-1:0] capture_en,
    input  logic [NCH-1:0] clear_ch,
    input  phase_t         phase,
    output logic [NCH-1:0] pend,
    output logic [NCH-1:0] late
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic seen;
        assign seen = capture_en[c] && !line_in[c];

        always_ff @(posedge clk) begin
            if (rst) begin
                pend[c] <= 1'b0;
                late[c] <= 1'b0;
            end else if (clear_ch[c]) begin
                pend[c] <= 1'b0;
                late[c] <= 1'b0;
            end else if (seen) begin
                pend[c] <= 1'b1;
                late[c] <= is_late_phase(phase);
            end else if (phase == PH_T1) begin
                late[c] <= 1'b0;
            end
        end

        AST_CAPTURE_KEPT: assert property (@(posedge clk) disable iff (rst)
            (seen && !clear_ch[c]) |=> pend[c]) else $error("capture lost"); // R2
    end

endmodule

// File: rtl/rg_grant_select.sv
module rg_grant_select
    import rg_pkg::*;
#(
    parameter int NCH  = 2,
    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  pend,
    input  logic [NCH-1:0]  late,
    input  phase_t          phase,
    input  logic            lock_i,
    input  logic            split_i,
    input  logic            inta_i,
    input  logic            own_bus,
    output logic [NCH-1:0]  grant,
    output logic [IDXW-1:0] grant_idx,
    output logic            grant_any
);

    logic           window;
    logic [NCH-1:0] eligible;

    always_comb begin
        window = own_bus && grant_window(phase, lock_i, split_i, inta_i);
        for (int i = 0; i < NCH; i++)
            eligible[i] = pend[i] && !(late[i] && phase != PH_IDLE);
    end

    // Scan from the highest channel down, so the lowest eligible wins.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        if (window) begin
            for (int i = NCH - 1; i >= 0; i--) begin
                if (eligible[i]) begin
                    grant     = '0;
                    grant[i]  = 1'b1;
                    grant_idx = IDXW'(i);
                end
            end
        end
    end

    assign grant_any = |grant;

    AST_ONE_GRANT:   assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) else $error("multi grant"); // R2
    AST_GRANT_PHASE: assert property (@(posedge clk) disable iff (rst)
        grant_any |-> (phase == PH_T4 || phase == PH_IDLE)) else $error("grant phase"); // R3
    AST_LOCK_BLOCK:  assert property (@(posedge clk) disable iff (rst)
        lock_i |-> !grant_any) else $error("grant under lock"); // R6
    AST_SPLIT_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T4 && (split_i || inta_i)) |-> !grant_any) else $error("grant blocked cycle"); // R5
    AST_LOW_WINS:    assert property (@(posedge clk) disable iff (rst)
        (grant_any && eligible[0]) |-> grant[0]) else $error("priority"); // R7

endmodule

// File: rtl/rg_owner_fsm.sv
module rg_owner_fsm
    import rg_pkg::*;
#(
    parameter int NCH  = 2,
    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  line_in,
    input  logic [NCH-1:0]  grant,
    input  logic            grant_any,
    input  logic [IDXW-1:0] grant_idx,
    output own_state_t      state,
    output logic [NCH-1:0]  capture_en,
    output logic            own_bus,
    output logic            float_o
);

    logic [IDXW-1:0] owner;
    logic [NCH-1:0]  owner_mask;
    logic            release_seen;

    always_comb begin
        owner_mask        = '0;
        owner_mask[owner] = 1'b1;
        release_seen      = (line_in & owner_mask) == '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OWN;
            owner <= '0;
        end else begin
            unique case (state)
                ST_OWN: if (grant_any) begin
                    state <= ST_HELD;
                    owner <= grant_idx;
                end
                ST_HELD: if (release_seen) state <= ST_DEAD;
                ST_DEAD: state <= ST_OWN;
                default: state <= ST_OWN;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_OWN:  capture_en = ~grant;
            ST_HELD: capture_en = ~owner_mask;
            default: capture_en = '1;
        endcase
    end

    assign own_bus = (state == ST_OWN);
    assign float_o = (state != ST_OWN);

    AST_GRANT_FLOATS: assert property (@(posedge clk) disable iff (rst)
        grant_any |=> (state == ST_HELD)) else $error("no float after grant"); // R3
    AST_HOLD_UNTIL:   assert property (@(posedge clk) disable iff (rst)
        (state == ST_HELD && !release_seen) |=> (state == ST_HELD)) else $error("float ended early"); // R8
    AST_DEAD_ONE:     assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEAD) |=> (state == ST_OWN)) else $error("dead clock length"); // R9
    AST_QUIET_FLOAT:  assert property (@(posedge clk) disable iff (rst)
        (state != ST_OWN) |-> (grant == '0)) else $error("drive while floated"); // R9

endmodule

// File: rtl/rg_bus_arbiter.sv
module rg_bus_arbiter
    import rg_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] line_in,
    input  logic [2:0]     bus_phase,
    input  logic           locked,
    input  logic           inta_first,
    input  logic           split_low_half,
    output logic [NCH-1:0] line_drive_low,
    output logic           bus_float
);

    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;

    phase_t          phase;
    own_state_t      state;
    logic [NCH-1:0]  pend, late, grant, capture_en;
    logic [IDXW-1:0] grant_idx;
    logic            grant_any, own_bus, float_w;

    assign phase = phase_t'(bus_phase);

    rg_line_monitor #(.NCH(NCH)) u_mon (
        .clk(clk), .rst(rst), .line_in(line_in), .capture_en(capture_en),
        .clear_ch(grant), .phase(phase), .pend(pend), .late(late)
    );

    rg_grant_select #(.NCH(NCH)) u_sel (
        .clk(clk), .rst(rst), .pend(pend), .late(late), .phase(phase),
        .lock_i(locked), .split_i(split_low_half), .inta_i(inta_first),
        .own_bus(own_bus), .grant(grant), .grant_idx(grant_idx),
        .grant_any(grant_any)
    );

    rg_owner_fsm #(.NCH(NCH)) u_fsm (
        .clk(clk), .rst(rst), .line_in(line_in), .grant(grant),
        .grant_any(grant_any), .grant_idx(grant_idx), .state(state),
        .capture_en(capture_en), .own_bus(own_bus), .float_o(float_w)
    );

    assign line_drive_low = grant;
    assign bus_float      = float_w;

    AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        (|line_drive_low) |=> (line_drive_low == '0)) else $error("grant wider than one clock"); // R2
    AST_FLOAT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (|line_drive_low) |=> bus_float) else $error("float missing"); // R3

endmodule

// File: tb/rg_bus_arbiter_test.sv
module rg_bus_arbiter_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] m_low;
    logic [1:0] line_w;
    logic [2:0] bus_phase;
    logic       locked, inta_first, split_low_half;
    logic [1:0] line_drive_low;
    logic       bus_float;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Model state: 0 own, 1 float held, 2 dead clock
    int         ms;
    int         mowner;
    logic [1:0] mpend, mlate;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_w = ~(m_low | line_drive_low);

    rg_bus_arbiter #(.NCH(2)) uut (
        .clk(clk), .rst(rst), .line_in(line_w), .bus_phase(bus_phase),
        .locked(locked), .inta_first(inta_first), .split_low_half(split_low_half),
        .line_drive_low(line_drive_low), .bus_float(bus_float)
    );

    function automatic logic [1:0] exp_drive(input logic [2:0] ph, input logic lk,
                                             input logic sp, input logic ia);
        logic [1:0] d;
        logic win;
        d = 2'b00;
        win = !lk && (ph == 3'd0 || (ph == 3'd5 && !sp && !ia));
        if (ms == 0 && win) begin
            for (int c = 0; c < 2; c++)
                if (d == 2'b00 && mpend[c] && !(mlate[c] && ph != 3'd0))
                    d[c] = 1'b1;
        end
        return d;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [2:0] ph, input logic lk, input logic sp,
                        input logic ia, input logic [1:0] ml, input string tag);
        logic [1:0] d, ln;
        @(negedge clk);
        bus_phase = ph; locked = lk; split_low_half = sp; inta_first = ia; m_low = ml;
        #1;
        d = exp_drive(ph, lk, sp, ia);
        check({tag, " drive"}, 32'(line_drive_low), 32'(d));
        check({tag, " float"}, 32'(bus_float), 32'(ms != 0));
        ln = ~(ml | d);
        for (int c = 0; c < 2; c++)
            if (ph == 3'd1) mlate[c] = 1'b0;
        case (ms)
            0: begin
                for (int c = 0; c < 2; c++)
                    if (!ln[c] && !d[c]) begin mpend[c] = 1'b1; mlate[c] = (ph >= 3'd3); end
                if (d != 2'b00) begin
                    mowner = d[0] ? 0 : 1;
                    mpend[mowner] = 1'b0; mlate[mowner] = 1'b0;
                    ms = 1;
                end
            end
            1: begin
                for (int c = 0; c < 2; c++)
                    if (!ln[c] && c != mowner) begin mpend[c] = 1'b1; mlate[c] = (ph >= 3'd3); end
                if (!ln[mowner]) ms = 2;
            end
            default: begin
                for (int c = 0; c < 2; c++)
                    if (!ln[c]) begin mpend[c] = 1'b1; mlate[c] = (ph >= 3'd3); end
                ms = 0;
            end
        endcase
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(3'd0, 0, 0, 0, 2'b00, tag);
    endtask

    // Runs one bus cycle T1,T2,T3,T4; pulse chosen channel in phase pp
    task automatic cyc(input logic [2:0] pp, input logic [1:0] ml, input logic lk,
                       input logic sp, input logic ia, input string tag);
        for (int p = 1; p <= 5; p++) begin
            if (p == 4) continue;
            step(3'(p), lk, (p == 5) ? sp : 1'b0, (p == 5) ? ia : 1'b0,
                 (3'(p) == pp) ? ml : 2'b00, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [2:0] ph;
        void'($urandom(32'd1234));
        rst = 1; m_low = 0; bus_phase = 0; locked = 0; inta_first = 0; split_low_half = 0;
        ms = 0; mowner = 0; mpend = 0; mlate = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 drive", 32'(line_drive_low), 32'd0);
        check("R1 float", 32'(bus_float), 32'd0);
        @(negedge clk); rst = 0;
        idle(2, "R1");

        // Idle request on channel 0, grant next clock, float after
        step(3'd0, 0, 0, 0, 2'b01, "R3");
        #1 check("R3 pending before grant", 32'(mpend), 32'd1);
        step(3'd0, 0, 0, 0, 2'b00, "R3");
        check("R2 one grant clock", 32'(mowner), 32'd0);
        idle(2, "R8");
        step(3'd0, 0, 0, 0, 2'b10, "R8");   // other channel during float
        idle(2, "R8");
        step(3'd0, 0, 0, 0, 2'b01, "R9");   // release
        step(3'd0, 0, 0, 0, 2'b00, "R9");   // dead clock
        step(3'd0, 0, 0, 0, 2'b00, "R9");   // ch1 granted here
        check("R9 ch1 serviced", 32'(mowner), 32'd1);
        idle(1, "R9");
        step(3'd0, 0, 0, 0, 2'b10, "R9");
        idle(2, "R9");

        // Late request in T3 must wait a whole cycle
        cyc(3'd3, 2'b10, 0, 0, 0, "R4");
        check("R4 still pending", 32'(mpend[1]), 32'd1);
        cyc(3'd0, 2'b00, 0, 0, 0, "R4");
        step(3'd0, 0, 0, 0, 2'b10, "R4");
        idle(2, "R4");

        // Split and interrupt-acknowledge block T4
        cyc(3'd1, 2'b01, 0, 1, 0, "R5");
        cyc(3'd0, 2'b00, 0, 0, 1, "R5");
        check("R5 still pending", 32'(mpend[0]), 32'd1);
        // Lock blocks, then idle releases
        cyc(3'd0, 2'b00, 1, 0, 0, "R6");
        step(3'd0, 1, 0, 0, 2'b00, "R6");
        check("R6 still pending", 32'(mpend[0]), 32'd1);
        step(3'd0, 0, 0, 0, 2'b00, "R6");
        idle(1, "R6");
        step(3'd0, 0, 0, 0, 2'b01, "R6");
        idle(2, "R6");

        // Both at once
        step(3'd0, 0, 0, 0, 2'b11, "R7");
        step(3'd0, 0, 0, 0, 2'b00, "R7");
        check("R7 ch0 first", 32'(mowner), 32'd0);
        step(3'd0, 0, 0, 0, 2'b01, "R7");
        idle(4, "R7");
        step(3'd0, 0, 0, 0, 2'b10, "R7");
        idle(3, "R7");

        // Random traffic
        ph = 3'd0;
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] ml;
            logic lk, sp, ia;
            ml[0] = ($urandom % 7) == 0;
            ml[1] = ($urandom % 7) == 0;
            lk = ($urandom % 10) == 0;
            sp = ($urandom % 4) == 0;
            ia = ($urandom % 5) == 0;
            step(ph, lk, sp, ia, ml, "R2");
            case (ph)
                3'd0: ph = ($urandom % 2) ? 3'd1 : 3'd0;
                3'd3: ph = ($urandom % 3 == 0) ? 3'd4 : 3'd5;
                3'd4: ph = ($urandom % 2) ? 3'd4 : 3'd5;
                3'd5: ph = ($urandom % 3 == 0) ? 3'd0 : 3'd1;
                default: ph = ph + 3'd1;
            endcase
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule